// File: doc/BRIEF.md
# SMBus Indexed Register Slave

This block is a two-wire serial slave. It gives an external bus controller read and write access to a small bank of 8-bit control registers. The clock and data lines are open-drain. The block sees them as plain inputs and pulls data low through a single output enable. Both lines are oversampled by the block's own system clock, which must run several times faster than the serial clock.

The command byte sent after the address picks the access type:

- With its top bit set, the command selects an indexed single-register access. The lower seven bits give the offset.
- With the command at zero, it selects a sequential block access that starts at offset 0. Block transfers carry a byte count in both directions:
  - In a block write the count is received and then ignored.
  - In a block read the slave first returns the number of implemented registers.

Every register value is presented at once on a parallel bus for the surrounding logic to read. Two kinds of read-only content appear on that bus and ignore writes:

- a field that mirrors a strap input;
- a fixed identification byte.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset the sda output enable is 0 and the registers at offsets 0..14 read 0x40|strap, 7F, 00, FF, 47, BF, 03, 41, 00, 18, 0F, 00, 00, 00, 40 (hex). Offset n occupies regs_o[8n+7:8n].
- R2: The slave acknowledges the 8-bit address 0xD2 (write) and 0xD3 (read), that is, 7-bit address 0x69 followed by the read bit. For any other address it gives no acknowledge and ignores all bytes until the next start.
- R3: A command byte with bit 7 = 1 selects an indexed access to the offset in bits 6:0. A data byte written after it is acknowledged and stored at that offset, MSB first on the wire.
- R4: An indexed read (command byte, repeated start, read address) returns the register at the stored offset, MSB first. The master then ends with a NACK and a stop.
- R5: A block write (command 0x00, a count byte that is acknowledged and ignored, then data bytes) stores the data at offsets 0, 1, 2 and so on. The transfer may stop after any complete byte.
- R6: A block read (command 0x00, repeated start, read address) returns the count byte 0x0F first, then the registers from offset 0 upward. It ends at the first master NACK, after which the line is released.
- R7: A command byte with bit 7 = 0 and a nonzero value in bits 6:0 is not acknowledged, and the transaction is dropped.
- R8: Offset 0 bits 4:0 always equal strap_i, and offset 7 always reads 0x41. Writes to those bits are acknowledged but have no effect. Writes to offsets above 14 are ignored, and reads there return 0x00.
- R9: A start or stop seen in the middle of a byte aborts the transaction and resets the bit count. The partial byte is never written, and the next transaction works normally.
- R10: The sda output enable changes only while scl is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 5 | Strap levels mirrored into offset 0 bits 4:0 |
| regs_o | output | 120 | All register values; offset n at bits 8n+7:8n |

## Verification
The assertions check four properties on every cycle:
- The output enable moves only while scl is low.
- The identification byte never leaves 0x41.
- The strap field always follows strap_i.
- Every change to writable register content coincides with the slave starting an acknowledge.

Only the bench scenarios can show the behaviour that depends on protocol order:
- address rejection;
- command decoding;
- the block count byte;
- offset sequencing in both directions;
- aborts in the middle of a byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_CNT,
    S_WDATA,
    S_RDATA
  } smb_state_e;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h47;
      5:       return 8'hBF;
      6:       return 8'h03;
      7:       return 8'h41;
      9:       return 8'h18;
      10:      return 8'h0F;
      14:      return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_cur  = scl_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_cur  = sda_p[STAGES-1];
  assign sda_prev = sda_p[STAGES];

  assign scl_rise_o = scl_cur & ~scl_prev;
  assign scl_fall_o = ~scl_cur & scl_prev;
  assign start_o    = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_o     = scl_cur & scl_prev & ~sda_prev & sda_cur;
  assign sda_o      = sda_cur;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int unsigned NREG       = 15,
  parameter int unsigned STRAP_IDX  = 0,
  parameter int unsigned STRAP_W    = 5,
  parameter int unsigned CONST_IDX  = 7,
  parameter logic [7:0]  CONST_BYTE = 8'h41
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [6:0]           idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [STRAP_W-1:0]   strap_i,
  output logic [7:0]           rd_data_o,
  output logic [NREG*8-1:0]    regs_o
);
  localparam int unsigned SEL_W = $clog2(NREG);

  logic [NREG-1:0][7:0] view;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == CONST_IDX) begin : g_const
      assign view[g] = CONST_BYTE;
    end else begin : g_store
      localparam logic [7:0] WMASK = (g == STRAP_IDX) ? ~8'((1 << STRAP_W) - 1) : 8'hFF;
      localparam logic [7:0] RSTV  = smb_pkg::reg_default(g) & WMASK;
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RSTV;
        else if (wr_en_i && idx_i == 7'(g)) q <= wr_data_i & WMASK;
      end
      if (g == STRAP_IDX) begin : g_strap
        assign view[g] = q | {{(8-STRAP_W){1'b0}}, strap_i};
      end else begin : g_plain
        assign view[g] = q;
      end
    end
  end

  assign regs_o    = view;
  assign rd_data_o = (idx_i < 7'(NREG)) ? view[idx_i[SEL_W-1:0]] : 8'h00;
endmodule

// File: rtl/smb_proto.sv
module smb_proto import smb_pkg::*; #(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NREG     = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [7:0] rd_data_i,
  output logic       wr_en_o,
  output logic [6:0] idx_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  smb_state_e st_q, nxt_q;
  logic [3:0] bit_q;
  logic [7:0] rx_q, tx_q;
  logic [6:0] ptr_q;
  logic       byte_mode_q, cnt_phase_q, mack_q, drv_q;
  logic       rx_state, byte_end, slot_end;
  logic [7:0] first_tx;

  assign rx_state  = st_q inside {S_ADDR, S_CMD, S_CNT, S_WDATA};
  assign byte_end  = scl_fall_i && bit_q == 4'd8;
  assign slot_end  = scl_fall_i && bit_q == 4'd9;
  assign first_tx  = byte_mode_q ? rd_data_i : COUNT_BYTE;
  assign wr_en_o   = byte_end && st_q == S_WDATA;
  assign idx_o     = ptr_q;
  assign wr_data_o = rx_q;
  assign sda_oe_o  = drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      nxt_q       <= S_IDLE;
      bit_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      byte_mode_q <= 1'b1;
      cnt_phase_q <= 1'b0;
      mack_q      <= 1'b0;
      drv_q       <= 1'b0;
    end else if (start_i) begin
      st_q  <= S_ADDR;
      bit_q <= '0;
      drv_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= S_IDLE;
      bit_q <= '0;
      drv_q <= 1'b0;
    end else if (st_q != S_IDLE) begin
      if (scl_rise_i) begin
        if (bit_q != 4'd9) bit_q <= bit_q + 4'd1;
        if (bit_q < 4'd8 && rx_state) rx_q <= {rx_q[6:0], sda_i};
        if (bit_q == 4'd8 && st_q == S_RDATA) begin
          mack_q <= !sda_i;
          if (!sda_i) begin
            cnt_phase_q <= 1'b0;
            // count byte does not advance the offset
            if (!byte_mode_q && !cnt_phase_q) ptr_q <= ptr_q + 7'd1;
          end
        end
      end else if (byte_end) begin
        drv_q <= 1'b0;
        if (rx_state) begin
          case (st_q)
            S_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                drv_q <= 1'b1;
                nxt_q <= rx_q[0] ? S_RDATA : S_CMD;
              end else begin
                st_q <= S_IDLE;
              end
            end
            S_CMD: begin
              if (rx_q[7]) begin
                drv_q       <= 1'b1;
                byte_mode_q <= 1'b1;
                ptr_q       <= rx_q[6:0];
                nxt_q       <= S_WDATA;
              end else if (rx_q[6:0] == 7'd0) begin
                drv_q       <= 1'b1;
                byte_mode_q <= 1'b0;
                ptr_q       <= '0;
                nxt_q       <= S_CNT;
              end else begin
                st_q <= S_IDLE;
              end
            end
            S_CNT: begin
              drv_q <= 1'b1;
              nxt_q <= S_WDATA;
            end
            default: begin
              drv_q <= 1'b1;
              nxt_q <= S_WDATA;
              if (!byte_mode_q) ptr_q <= ptr_q + 7'd1;
            end
          endcase
        end
      end else if (slot_end) begin
        bit_q <= '0;
        drv_q <= 1'b0;
        if (rx_state) begin
          st_q <= nxt_q;
          if (nxt_q == S_RDATA) begin
            tx_q        <= first_tx;
            cnt_phase_q <= !byte_mode_q;
            drv_q       <= !first_tx[7];
          end
        end else if (mack_q) begin
          tx_q  <= rd_data_i;
          drv_q <= !rd_data_i[7];
        end else begin
          st_q <= S_IDLE;
        end
      end else if (scl_fall_i && st_q == S_RDATA && bit_q != 4'd0) begin
        drv_q <= !tx_q[3'd7 - bit_q[2:0]];
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int unsigned NREG        = 15,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 5,
  parameter int unsigned STRAP_IDX   = 0,
  parameter int unsigned CONST_IDX   = 7,
  parameter logic [7:0]  CONST_BYTE  = 8'h41
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  regs_o
);
  logic scl_rise, scl_fall, start, stop, sda_s;
  logic wr_en;
  logic [6:0] idx;
  logic [7:0] wr_data, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop),
    .sda_o      (sda_s)
  );

  smb_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_s),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .idx_o      (idx),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  smb_reg_bank #(
    .NREG(NREG), .STRAP_IDX(STRAP_IDX), .STRAP_W(STRAP_W),
    .CONST_IDX(CONST_IDX), .CONST_BYTE(CONST_BYTE)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .idx_i     (idx),
    .wr_data_i (wr_data),
    .strap_i   (strap_i),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int unsigned NREG       = 15,
  parameter int unsigned STRAP_W    = 5,
  parameter int unsigned STRAP_IDX  = 0,
  parameter int unsigned CONST_IDX  = 7,
  parameter logic [7:0]  CONST_BYTE = 8'h41
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic [STRAP_W-1:0] strap_i,
  input logic [NREG*8-1:0]  regs_o
);
  logic [NREG*8-1:0] wr_view;

  always_comb begin
    wr_view = regs_o;
    wr_view[STRAP_IDX*8 +: STRAP_W] = '0;
  end

  a_r10_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  a_r8_const_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[CONST_IDX*8 +: 8] == CONST_BYTE);

  a_r8_strap_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[STRAP_IDX*8 +: STRAP_W] == strap_i);

  a_r3_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_view) |-> (sda_oe_o && !$past(sda_oe_o)));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(
  .NREG(NREG), .STRAP_W(STRAP_W), .STRAP_IDX(STRAP_IDX),
  .CONST_IDX(CONST_IDX), .CONST_BYTE(CONST_BYTE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .strap_i  (strap_i),
  .regs_o   (regs_o)
);

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam int NREG = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [4:0] strap = 5'h0A;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int r10_viol = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smb_reg_slave u_smb_reg_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .strap_i  (strap),
    .regs_o   (regs)
  );

  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) r10_viol <= r10_viol + 1;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] exp_def(int i);
    case (i)
      0: return 8'h40 | {3'b000, strap};
      1: return 8'h7F; 3: return 8'hFF; 4: return 8'h47; 5: return 8'hBF;
      6: return 8'h03; 7: return 8'h41; 9: return 8'h18; 10: return 8'h0F;
      14: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_at(int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl = 1'b1; q(); ack = ~sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic rd_byte(logic nack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); v[i] = sda_line; q(); scl = 1'b0;
    end
    q(); sda_m = nack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic byte_write(logic [6:0] off, logic [7:0] d, output logic ack);
    logic a0, a1;
    bus_start(); wr_byte(8'hD2, a0); wr_byte({1'b1, off}, a1); wr_byte(d, ack); bus_stop();
  endtask

  task automatic byte_read(logic [6:0] off, output logic [7:0] v);
    logic a;
    bus_start(); wr_byte(8'hD2, a); wr_byte({1'b1, off}, a);
    bus_start(); wr_byte(8'hD3, a); rd_byte(1'b1, v); bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);
    for (int i = 0; i < NREG; i++) chk($sformatf("R1 default offset %0d", i), reg_at(i), exp_def(i));
    strap = 5'h15; q();
    chk("R8 strap mirror", reg_at(0), 8'h55);
    strap = 5'h0A; q();
    chk("R8 strap mirror restore", reg_at(0), 8'h4A);
  endtask

  task automatic t_byte_wr_rd();
    logic a; logic [7:0] v;
    bus_start(); wr_byte(8'hD2, a); chk("R2 address ack", {7'd0, a}, 8'h01);
    wr_byte(8'h83, a); chk("R3 command ack", {7'd0, a}, 8'h01);
    wr_byte(8'h5A, a); chk("R3 data ack", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R3 stored offset 3", reg_at(3), 8'h5A);
    byte_read(7'd3, v); chk("R4 read offset 3", v, 8'h5A);
    byte_read(7'd9, v); chk("R4 read offset 9", v, 8'h18);
    chk("R4 line released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_block_wr();
    logic a;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a);
    chk("R5 block command ack", {7'd0, a}, 8'h01);
    wr_byte(8'h03, a); chk("R5 count ack", {7'd0, a}, 8'h01);
    wr_byte(8'hA1, a); wr_byte(8'hB2, a); wr_byte(8'hC3, a);
    chk("R5 last data ack", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R5 offset 0 (strap kept)", reg_at(0), 8'hAA);
    chk("R5 offset 1", reg_at(1), 8'hB2);
    chk("R5 offset 2", reg_at(2), 8'hC3);
    chk("R5 offset 3 untouched", reg_at(3), 8'h5A);
  endtask

  task automatic t_block_rd();
    logic a; logic [7:0] v;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h00, a);
    bus_start(); wr_byte(8'hD3, a); chk("R6 read address ack", {7'd0, a}, 8'h01);
    rd_byte(1'b0, v); chk("R6 count byte", v, 8'h0F);
    rd_byte(1'b0, v); chk("R6 offset 0", v, 8'hAA);
    rd_byte(1'b0, v); chk("R6 offset 1", v, 8'hB2);
    rd_byte(1'b1, v); chk("R6 offset 2", v, 8'hC3);
    chk("R6 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start(); wr_byte(8'hA8, a); chk("R2 foreign address nack", {7'd0, a}, 8'h00);
    wr_byte(8'h84, a); chk("R2 ignored command", {7'd0, a}, 8'h00);
    wr_byte(8'h11, a); chk("R2 ignored data", {7'd0, a}, 8'h00);
    bus_stop();
    chk("R2 offset 4 unchanged", reg_at(4), 8'h47);
  endtask

  task automatic t_read_only();
    logic a; logic [7:0] v;
    byte_write(7'd7, 8'hFF, a);
    chk("R8 const write acked", {7'd0, a}, 8'h01);
    chk("R8 const byte kept", reg_at(7), 8'h41);
    byte_write(7'd0, 8'h00, a);
    chk("R8 strap bits kept", reg_at(0), 8'h0A);
    byte_write(7'h20, 8'h77, a);
    byte_read(7'h20, v); chk("R8 out of range reads zero", v, 8'h00);
  endtask

  task automatic t_block_nz();
    logic a;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h05, a);
    chk("R7 nonzero block command nack", {7'd0, a}, 8'h00);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h84, a);
    send_bits(8'hF0, 4); bus_stop();
    chk("R9 stop aborts partial byte", reg_at(4), 8'h47);
    byte_write(7'd4, 8'h3C, a);
    chk("R9 next write after stop", reg_at(4), 8'h3C);
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h85, a);
    send_bits(8'hE0, 3);
    bus_start(); wr_byte(8'hD2, a); wr_byte(8'h85, a); wr_byte(8'h66, a); bus_stop();
    chk("R9 restart mid byte", reg_at(5), 8'h66);
    chk("R10 oe moved only with scl low", 8'(r10_viol), 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    t_reset();
    t_byte_wr_rd();
    t_block_wr();
    t_block_rd();
    t_bad_addr();
    t_read_only();
    t_block_nz();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule